// File: doc/BRIEF.md
# Bit-Sliced LFSR Input Debouncer

This block cleans up a word of noisy raw inputs, such as mechanical switch contacts, and presents one settled level per input. All inputs are handled in parallel. Each input has a short settle counter. The counters are stored across the word rather than along it: there is one register per counter stage, and that register holds the stage bit of every input. Each counter is a maximal-length linear feedback shift register (LFSR). Advancing it costs one XOR per tap, and there is no carry chain, whatever the input count.

An external pulse, `sample_en_i`, sets the sampling rate. On each such tick the raw word is captured once, and every counter is stepped. The raw word is compared with the debounced word. Inputs that agree have their counters put back to all-ones. An input that disagrees and whose counter has returned to all-ones after the step has its debounced level flipped. A one-cycle per-bit strobe marks each flip, so downstream logic can detect edges without keeping its own copy of the levels.

Top module: `vert_lfsr_debounce`

## Requirements
- R1: While `rst_i` is high at a clock edge, `debounced_o` loads the parameter `RESET_VALUE`, `changed_o` goes to all zeros and every counter stage loads 1.
- R2: On a clock edge where `sample_en_i` is low, `debounced_o` and the counters do not change and `changed_o` is zero. The value on `raw_i` in such cycles has no effect, whether it agrees with `debounced_o` or not.
- R3: A raw bit that differs from its debounced bit on `2**STAGES - 1` consecutive ticks (15 for the default of 4 stages) makes that debounced bit take the raw value on the last of those ticks. After one tick fewer it has not changed yet.
- R4: A tick on which a raw bit agrees with its debounced bit restarts that bit's count. A disagreement lasting fewer than `2**STAGES - 1` ticks never reaches the output.
- R5: `changed_o[i]` is high for exactly one clock cycle, the cycle that follows the tick on which `debounced_o[i]` flipped. It is low otherwise.
- R6: Each bit counts on its own. Bits whose disagreements start on different ticks flip on their own ticks, and several bits may flip on the same tick.
- R7: After a flip the count starts again from the beginning. A raw bit that returns to its old level on the very next tick needs a further full `2**STAGES - 1` differing ticks before it is reported.
- R8: Each counter steps on every tick. Every stage moves one place toward stage 0, the old stage 0 bit enters the top stage, and when that old bit is 1 it is also XORed into stage `TAP-1`. TAP is 3 for 4 stages, 3 for 5 stages and 5 for 6 stages, so every supported `STAGES` value has a period of `2**STAGES - 1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sample_en_i | input | 1 | Sample tick; one update per cycle in which it is high |
| raw_i | input | N | Undebounced input word |
| debounced_o | output | N | Settled level of each input |
| changed_o | output | N | One-cycle strobe per bit that flipped on the previous tick |

## Verification
Two things can happen in the same cycle. One bit can complete its count and flip while a neighbouring bit is still mid-count. A bit can also flip on one tick and then see the opposite raw level on the very next tick. The bench provokes the first case by starting two bits' disagreements five ticks apart. It provokes the second by reversing a bit right after its flip. In both cases the flipping bit must strobe alone, on its own tick, and the other bit must keep its count. A behavioural per-bit run-length model is compared with the outputs on every clock, for 4, 5 and 6 stages running side by side.

// File: rtl/debounce_pkg.sv
package debounce_pkg;

    // Two-tap feedback position for each supported stage count
    function automatic int unsigned tap_of(input int unsigned stages);
        case (stages)
            4:       tap_of = 3;
            5:       tap_of = 3;
            6:       tap_of = 5;
            default: tap_of = 3;
        endcase
    endfunction

    // Number of consecutive differing ticks before a flip is reported
    function automatic int unsigned settle_ticks(input int unsigned stages);
        settle_ticks = (1 << stages) - 1;
    endfunction

    // Per-tick decision vectors handed from compare to state logic
    typedef enum logic [0:0] {
        TICK_IDLE = 1'b0,
        TICK_RUN  = 1'b1
    } tick_mode_e;

endpackage

// File: rtl/dbn_compare.sv
module dbn_compare #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] raw_i,
    input  logic [N-1:0] level_i,
    output logic [N-1:0] differ_o,
    output logic [N-1:0] agree_o
);
    always_comb begin
        differ_o = raw_i ^ level_i;
        agree_o  = ~differ_o;
    end
endmodule

// File: rtl/dbn_lfsr_bank.sv
module dbn_lfsr_bank
    import debounce_pkg::*;
#(
    parameter int unsigned N      = 8,
    parameter int unsigned STAGES = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  tick_mode_e       mode_i,
    input  logic [N-1:0]     restart_i,
    output logic [N-1:0]     settled_o
);
    localparam int unsigned TAP     = tap_of(STAGES);
    localparam int unsigned TAP_IDX = TAP - 1;

    logic [N-1:0] stage_q   [STAGES];
    logic [N-1:0] stepped   [STAGES];
    logic [N-1:0] stage_d   [STAGES];

    // Advance: shift toward stage 0, old stage 0 feeds the top stage and the tap
    for (genvar k = 0; k < STAGES; k++) begin : g_step
        if (k == STAGES - 1) begin : g_top
            assign stepped[k] = stage_q[0];
        end else if (k == TAP_IDX) begin : g_tap
            assign stepped[k] = stage_q[k+1] ^ stage_q[0];
        end else begin : g_plain
            assign stepped[k] = stage_q[k+1];
        end
        assign stage_d[k] = (mode_i == TICK_RUN) ? (stepped[k] | restart_i) : stage_q[k];
    end

    // All-ones detect taken after the advance step
    always_comb begin
        settled_o = '1;
        for (int k = 0; k < STAGES; k++) begin
            settled_o = settled_o & stepped[k];
        end
    end

    always_ff @(posedge clk_i) begin
        for (int k = 0; k < STAGES; k++) begin
            if (rst_i) begin
                stage_q[k] <= '1;
            end else begin
                stage_q[k] <= stage_d[k];
            end
        end
    end
endmodule

// File: rtl/dbn_state.sv
module dbn_state
    import debounce_pkg::*;
#(
    parameter int unsigned N           = 8,
    parameter logic [N-1:0] RESET_VALUE = '0
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  tick_mode_e   mode_i,
    input  logic [N-1:0] flip_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] strobe_o
);
    logic [N-1:0] flip_gated;

    always_comb begin
        flip_gated = (mode_i == TICK_RUN) ? flip_i : '0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            level_o  <= RESET_VALUE;
            strobe_o <= '0;
        end else begin
            level_o  <= level_o ^ flip_gated;
            strobe_o <= flip_gated;
        end
    end
endmodule

// File: rtl/vert_lfsr_debounce.sv
module vert_lfsr_debounce
    import debounce_pkg::*;
#(
    parameter int unsigned  N           = 8,
    parameter int unsigned  STAGES      = 4,
    parameter logic [N-1:0] RESET_VALUE = '0
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         sample_en_i,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] debounced_o,
    output logic [N-1:0] changed_o
);
    tick_mode_e   mode;
    logic [N-1:0] differ;
    logic [N-1:0] agree;
    logic [N-1:0] settled;
    logic [N-1:0] flip;

    assign mode = sample_en_i ? TICK_RUN : TICK_IDLE;

    dbn_compare #(.N(N)) u_cmp (
        .raw_i    (raw_i),
        .level_i  (debounced_o),
        .differ_o (differ),
        .agree_o  (agree)
    );

    dbn_lfsr_bank #(.N(N), .STAGES(STAGES)) u_bank (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .mode_i    (mode),
        .restart_i (agree),
        .settled_o (settled)
    );

    assign flip = differ & settled;

    dbn_state #(.N(N), .RESET_VALUE(RESET_VALUE)) u_state (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .mode_i   (mode),
        .flip_i   (flip),
        .level_o  (debounced_o),
        .strobe_o (changed_o)
    );
endmodule

// File: rtl/dbn_chk.sv
module dbn_chk #(
    parameter int unsigned  N           = 8,
    parameter logic [N-1:0] RESET_VALUE = '0
) (
    input logic         clk,
    input logic         rst,
    input logic         sample_en,
    input logic [N-1:0] raw,
    input logic [N-1:0] db,
    input logic [N-1:0] stb
);
    // R1
    reset_load_chk: assert property (@(posedge clk)
        rst |=> (db == RESET_VALUE && stb == '0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(db));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> (stb == '0));

    // R5
    strobe_edge_chk: assert property (@(posedge clk) disable iff (rst)
        sample_en |=> (stb == (db ^ $past(db))));

    // R3
    flip_to_raw_chk: assert property (@(posedge clk) disable iff (rst)
        sample_en |=> ((stb & (db ^ $past(raw))) == '0));
endmodule

bind vert_lfsr_debounce dbn_chk #(.N(N), .RESET_VALUE(RESET_VALUE)) u_chk (
    .clk       (clk_i),
    .rst       (rst_i),
    .sample_en (sample_en_i),
    .raw       (raw_i),
    .db        (debounced_o),
    .stb       (changed_o)
);

// File: tb/vert_lfsr_debounce_tb.sv
module vert_lfsr_debounce_tb;
    localparam logic [7:0] RV = 8'h5A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [7:0] raw = RV;
    logic [7:0] db_v  [3];
    logic [7:0] stb_v [3];

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] cur;

    always #4 clk = ~clk;

    vert_lfsr_debounce #(.N(8), .STAGES(4), .RESET_VALUE(RV)) u_dut (
        .clk_i(clk), .rst_i(rst), .sample_en_i(en), .raw_i(raw),
        .debounced_o(db_v[0]), .changed_o(stb_v[0]));
    vert_lfsr_debounce #(.N(8), .STAGES(5), .RESET_VALUE(RV)) u_dut_s5 (
        .clk_i(clk), .rst_i(rst), .sample_en_i(en), .raw_i(raw),
        .debounced_o(db_v[1]), .changed_o(stb_v[1]));
    vert_lfsr_debounce #(.N(8), .STAGES(6), .RESET_VALUE(RV)) u_dut_s6 (
        .clk_i(clk), .rst_i(rst), .sample_en_i(en), .raw_i(raw),
        .debounced_o(db_v[2]), .changed_o(stb_v[2]));

    // Behavioural model: per-bit run length of differing ticks
    int         period [3] = '{15, 31, 63};
    int         run [3][8];
    logic [7:0] m_db  [3];
    logic [7:0] m_stb [3];

    always @(posedge clk) begin
        for (int v = 0; v < 3; v++) begin
            if (rst) begin
                m_db[v]  = RV;
                m_stb[v] = '0;
                for (int b = 0; b < 8; b++) run[v][b] = 0;
            end else begin
                m_stb[v] = '0;
                if (en) begin
                    for (int b = 0; b < 8; b++) begin
                        if (raw[b] != m_db[v][b]) begin
                            run[v][b] = run[v][b] + 1;
                            if (run[v][b] == period[v]) begin
                                m_db[v][b]  = ~m_db[v][b];
                                m_stb[v][b] = 1'b1;
                                run[v][b]   = 0;
                            end
                        end else begin
                            run[v][b] = 0;
                        end
                    end
                end
            end
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Every-cycle comparison against the model (R3 R4 R5 R6 R7 R8)
    always @(negedge clk) begin
        if (!rst) begin
            for (int v = 0; v < 3; v++) begin
                chk(db_v[v],  m_db[v],  "R3/R8 model level");
                chk(stb_v[v], m_stb[v], "R5 model strobe");
            end
        end
    end

    task automatic tick(input logic [7:0] r, input logic e);
        raw = r;
        en  = e;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(db_v[0], RV, "R1 reset level");
        chk(stb_v[0], 8'h00, "R1 reset strobe");
        rst = 1'b0;
        cur = RV;

        // R8: period per stage count, bit5
        repeat (15) tick(cur ^ 8'h20, 1'b1);
        chk(db_v[0], cur ^ 8'h20, "R8 four stages period");
        repeat (15) tick(cur ^ 8'h20, 1'b1);
        chk(db_v[1], cur, "R8 five stages one short");
        tick(cur ^ 8'h20, 1'b1);
        chk(db_v[1], cur ^ 8'h20, "R8 five stages period");
        repeat (31) tick(cur ^ 8'h20, 1'b1);
        chk(db_v[2], cur, "R8 six stages one short");
        tick(cur ^ 8'h20, 1'b1);
        chk(db_v[2], cur ^ 8'h20, "R8 six stages period");
        cur = cur ^ 8'h20;
        tick(cur, 1'b1);

        // R3 / R5: bit0 exact count and strobe
        repeat (14) tick(cur ^ 8'h01, 1'b1);
        chk(db_v[0], cur, "R3 one tick short");
        tick(cur ^ 8'h01, 1'b1);
        chk(db_v[0], cur ^ 8'h01, "R3 flip on full count");
        chk(stb_v[0], 8'h01, "R5 strobe on flip");
        cur = cur ^ 8'h01;

        // R7: reverse immediately after the flip
        repeat (14) tick(cur ^ 8'h01, 1'b1);
        chk(stb_v[0], 8'h00, "R5 strobe one cycle only");
        chk(db_v[0], cur, "R7 restart after flip");
        tick(cur ^ 8'h01, 1'b1);
        chk(db_v[0], cur ^ 8'h01, "R7 second flip");
        cur = cur ^ 8'h01;

        // R4: glitch shorter than the count
        repeat (14) tick(cur ^ 8'h02, 1'b1);
        tick(cur, 1'b1);
        repeat (14) tick(cur ^ 8'h02, 1'b1);
        chk(db_v[0], cur, "R4 glitch ignored");
        tick(cur ^ 8'h02, 1'b1);
        chk(db_v[0], cur ^ 8'h02, "R4 count restarted");
        cur = cur ^ 8'h02;

        // R2: disabled cycles neither count nor restart
        repeat (10) tick(cur ^ 8'h04, 1'b1);
        repeat (10) tick(cur, 1'b0);
        chk(stb_v[0], 8'h00, "R2 no strobe when idle");
        repeat (10) tick(cur ^ 8'h04, 1'b0);
        chk(db_v[0], cur, "R2 idle holds level");
        repeat (4) tick(cur ^ 8'h04, 1'b1);
        chk(db_v[0], cur, "R2 count kept across idle");
        tick(cur ^ 8'h04, 1'b1);
        chk(db_v[0], cur ^ 8'h04, "R2 flip after resumed count");
        cur = cur ^ 8'h04;

        // R6: staggered bits
        repeat (5) tick(cur ^ 8'h08, 1'b1);
        repeat (10) tick(cur ^ 8'h18, 1'b1);
        chk(db_v[0], cur ^ 8'h08, "R6 first bit flips alone");
        chk(stb_v[0], 8'h08, "R6 first bit strobe");
        cur = cur ^ 8'h08;
        repeat (5) tick(cur ^ 8'h10, 1'b1);
        chk(db_v[0], cur ^ 8'h10, "R6 second bit own tick");
        chk(stb_v[0], 8'h10, "R6 second bit strobe");
        cur = cur ^ 8'h10;

        // R6: all bits together
        repeat (15) tick(~cur, 1'b1);
        chk(db_v[0], ~cur, "R6 all bits flip");
        chk(stb_v[0], 8'hFF, "R6 all strobes");
        cur = ~cur;
        tick(cur, 1'b1);
        chk(stb_v[0], 8'h00, "R5 strobe cleared");

        // R1: reset mid-count
        repeat (7) tick(cur ^ 8'h80, 1'b1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(db_v[0], RV, "R1 reset reload");
        chk(stb_v[0], 8'h00, "R1 reset strobe clear");
        summary();
    end
endmodule